// File: doc/BRIEF.md
# Grouped Event Interrupt Controller

This block collects ten single-cycle event pulses from a DMA bridge and turns them into three level interrupt lines. There are two USB events: transfer finished and address fault. There are eight audio events: half-buffer and full-buffer for playback and for record, on each of two audio channels. Each event has a sticky pending flag and a mask flag. All of these flags sit together in one 32-bit register. Software reads that register and writes it over a plain synchronous bus.

The interrupt lines are grouped by event kind rather than by source:
- Line 0 carries only the USB address fault.
- Line 1 carries the USB transfer finished event and every audio full-buffer event.
- Line 2 carries every audio half-buffer event.

Software clears a pending event by writing 0 to its flag. Writing 1 to a pending flag does nothing, so a driver can write back what it read while clearing selected bits.

Top module: `bei_top`

## Requirements
- R1: After reset, the register reads 0 and all three interrupt lines are 0.
- R2: An event pulse on `evt_i[n]` sets the pending flag of event n, whether or not that event is enabled. The flag is readable one cycle later at bit n (for n=0,1) or at bit n+14 (for n=2..9).
- R3: A write with 0 at the pending bit of an event clears that flag. A write with 1 at that bit leaves the flag unchanged.
- R4: The enable flag of event n is at bit n+8 (for n=0,1) or at bit n+22 (for n=2..9), and it stores exactly the value written.
- R5: When an event pulse and a clearing write to the same pending flag land in the same cycle, the flag ends up 1.
- R6: Bits 2 to 7 and bits 10 to 15 always read 0, and writes to them have no effect.
- R7: `irq_o[0]` is 1 exactly when event 1 is both pending and enabled.
- R8: `irq_o[1]` is 1 exactly when at least one of events 0, 2, 4, 6 or 8 is both pending and enabled.
- R9: `irq_o[2]` is 1 exactly when at least one of events 3, 5, 7 or 9 is both pending and enabled.
- R10: The interrupt lines are registered. They reflect the flag values one cycle after those flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Single-cycle event pulses, one per event number |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the flags |
| irq_o | output | 3 | Level interrupt lines 0 to 2 |

## Verification
Flag effects appear one clock edge after the stimulus:
- An event pulse or a register write driven before edge k shows up in `reg_rdata` right after edge k.
- The matching interrupt line follows one edge later, at edge k+1.

The bench drives its inputs on falling edges and samples on falling edges. A reference model updated on each rising edge keeps both delays: its interrupt expectation is formed from the flag values held before that edge's update. Directed checks cover these cases:
- The cycle in which a line is still low.
- The cycle in which it has just risen.
- The same-cycle set/clear collision.

// File: rtl/bei_pkg.sv
package bei_pkg;
  localparam int NUM_EVT   = 10;
  localparam int NUM_LINES = 3;
  localparam int REG_W     = 32;

  // enable bit position of event n
  function automatic int en_pos(input int n);
    return (n < 2) ? n + 8 : n + 22;
  endfunction

  // pending bit sits eight below its enable bit
  function automatic int st_pos(input int n);
    return en_pos(n) - 8;
  endfunction

  // interrupt line an event drives: 0 fault, 1 completion, 2 half
  function automatic int line_of(input int n);
    if (n == 1) return 0;
    if (n == 0) return 1;
    return (n % 2 == 0) ? 1 : 2;
  endfunction

  // mask of all defined register bits
  function automatic logic [REG_W-1:0] def_mask(input int nevt);
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < nevt; n++) begin
      m[st_pos(n)] = 1'b1;
      m[en_pos(n)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bei_flag_bank.sv
module bei_flag_bank
  import bei_pkg::*;
#(
  parameter int N_EVT = NUM_EVT,
  parameter int W     = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  output logic [N_EVT-1:0] stat_q,
  output logic [N_EVT-1:0] en_q
);
  logic [N_EVT-1:0] stat_d;
  logic [N_EVT-1:0] en_d;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    localparam int SP = st_pos(g);
    localparam int EP = en_pos(g);

    // next state: set has priority over a clearing write
    always_comb begin
      stat_d[g] = stat_q[g];
      en_d[g]   = en_q[g];
      if (evt_i[g]) begin
        stat_d[g] = 1'b1;
      end else if (we_i && !wdata_i[SP]) begin
        stat_d[g] = 1'b0;
      end
      if (we_i) begin
        en_d[g] = wdata_i[EP];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[g] <= 1'b0;
        en_q[g]   <= 1'b0;
      end else begin
        stat_q[g] <= stat_d[g];
        en_q[g]   <= en_d[g];
      end
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> stat_q[g]);

    // R3
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !wdata_i[SP] && !evt_i[g]) |=> !stat_q[g]);

    // R3
    one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wdata_i[SP] && !evt_i[g]) |=> $stable(stat_q[g]));

    // R4
    en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (en_q[g] == $past(wdata_i[EP])));
  end
endmodule

// File: rtl/bei_line_merge.sv
module bei_line_merge
  import bei_pkg::*;
#(
  parameter int N_EVT  = NUM_EVT,
  parameter int N_LINE = NUM_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  stat_i,
  input  logic [N_EVT-1:0]  en_i,
  output logic [N_LINE-1:0] irq_q
);
  logic [N_EVT-1:0]  live;
  logic [N_LINE-1:0] irq_d;

  assign live = stat_i & en_i;

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    always_comb begin
      irq_d[l] = 1'b0;
      for (int n = 0; n < N_EVT; n++) begin
        if (line_of(n) == l) irq_d[l] = irq_d[l] | live[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  // R7
  fault_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q[0] == $past(stat_i[1] && en_i[1])));

  // R9
  half_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q[2] == $past(|(stat_i & en_i & 10'b10_1010_1000))));

  // R8
  done_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q[1] == $past(|(stat_i & en_i & 10'b01_0101_0101))));
endmodule

// File: rtl/bei_top.sv
module bei_top
  import bei_pkg::*;
#(
  parameter int N_EVT  = NUM_EVT,
  parameter int N_LINE = NUM_LINES,
  parameter int W      = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             reg_we,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic [N_LINE-1:0] irq_o
);
  localparam logic [W-1:0] DEF_MASK = def_mask(N_EVT);

  logic [N_EVT-1:0] stat_q;
  logic [N_EVT-1:0] en_q;
  logic             unused_wbits;

  assign unused_wbits = ^(reg_wdata & ~DEF_MASK);

  bei_flag_bank #(.N_EVT(N_EVT), .W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .we_i    (reg_we),
    .wdata_i (reg_wdata),
    .stat_q  (stat_q),
    .en_q    (en_q)
  );

  bei_line_merge #(.N_EVT(N_EVT), .N_LINE(N_LINE)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_q),
    .en_i   (en_q),
    .irq_q  (irq_o)
  );

  // read path: pack flags into their fixed positions
  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < N_EVT; n++) begin
      reg_rdata[st_pos(n)] = stat_q[n];
      reg_rdata[en_pos(n)] = en_q[n];
    end
  end

  // R2
  evt_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[1] |=> reg_rdata[1]);
endmodule

// File: tb/sim_bei_top.sv
module sim_bei_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit m_st [10];
  bit m_en [10];
  logic [2:0] m_irq = '0;

  always #2 clk = ~clk;

  bei_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic int spos(input int n);
    return (n < 2) ? n : n + 14;
  endfunction

  function automatic int epos(input int n);
    return spos(n) + 8;
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int n = 0; n < 10; n++) begin
      w[spos(n)] = m_st[n];
      w[epos(n)] = m_en[n];
    end
    return w;
  endfunction

  function automatic logic [2:0] model_lines();
    logic [2:0] r = '0;
    for (int n = 0; n < 10; n++) begin
      if (m_st[n] && m_en[n]) begin
        if (n == 1)          r[0] = 1'b1;
        else if (n % 2 == 0) r[1] = 1'b1;
        else                 r[2] = 1'b1;
      end
    end
    return r;
  endfunction

  // reference model: lines use the flag values before this edge's update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 10; n++) begin
        m_st[n] = 0;
        m_en[n] = 0;
      end
      m_irq = '0;
    end else begin
      m_irq = model_lines();
      for (int n = 0; n < 10; n++) begin
        if (evt_i[n]) m_st[n] = 1;
        else if (reg_we && !reg_wdata[spos(n)]) m_st[n] = 0;
        if (reg_we) m_en[n] = reg_wdata[epos(n)];
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(reg_rdata == model_word(), "R2/R3/R4 register", reg_rdata, model_word());
      check(irq_o[0] == m_irq[0], "R7 line0", 32'(irq_o[0]), 32'(m_irq[0]));
      check(irq_o[1] == m_irq[1], "R8 line1", 32'(irq_o[1]), 32'(m_irq[1]));
      check(irq_o[2] == m_irq[2], "R9 line2", 32'(irq_o[2]), 32'(m_irq[2]));
    end
  end

  task automatic step(input logic [9:0] e, input bit we, input logic [31:0] d);
    @(negedge clk);
    evt_i = e;
    reg_we = we;
    reg_wdata = d;
  endtask

  task automatic idle();
    step('0, 0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_rdata == 32'h0, "R1 reset rdata", reg_rdata, 32'h0);
    check(irq_o == 3'b0, "R1 reset irq", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    idle();

    // R10: enabled event, line low on the first cycle, high on the second
    step('0, 1, 32'h0000_0200);        // enable event 1 (bit 9)
    step(10'b00_0000_0010, 0, '0);     // event 1 pulse
    idle();                            // flag set after previous edge
    check(reg_rdata[1] == 1'b1, "R2 flag bit1", reg_rdata, 32'h0000_0202);
    check(irq_o[0] == 1'b0, "R10 line0 not yet", 32'(irq_o), 32'h0);
    idle();
    check(irq_o[0] == 1'b1, "R10 line0 asserted", 32'(irq_o), 32'h1);

    // R2: flag set while masked, line stays low
    step('0, 1, 32'h0);
    step(10'b00_0001_0000, 0, '0);     // event 4, masked
    idle();
    idle();
    check(reg_rdata == 32'h0004_0000, "R2 masked flag bit18", reg_rdata, 32'h0004_0000);
    check(irq_o == 3'b0, "R8 masked line", 32'(irq_o), 32'h0);

    // R3: writing 1 keeps the flag, writing 0 clears it
    step('0, 1, 32'h0004_0000);
    idle();
    check(reg_rdata == 32'h0004_0000, "R3 write one keeps", reg_rdata, 32'h0004_0000);
    step('0, 1, 32'h0);
    idle();
    check(reg_rdata == 32'h0, "R3 write zero clears", reg_rdata, 32'h0);

    // R5: set and clear in the same cycle
    step(10'b10_0000_0000, 1, 32'h8000_0000); // event 9, enable 9, clear all
    idle();
    check(reg_rdata == 32'h8080_0000, "R5 set wins", reg_rdata, 32'h8080_0000);
    idle();
    check(irq_o == 3'b100, "R9 half line", 32'(irq_o), 32'h4);

    // R6: undefined bits read zero after an all-ones write
    step('0, 1, 32'hFFFF_FFFF);
    idle();
    check((reg_rdata & 32'h0000_FCFC) == 32'h0, "R6 undefined bits", reg_rdata, 32'hFF80_0300);
    check(reg_rdata == 32'hFF80_0300, "R4 enables stored", reg_rdata, 32'hFF80_0300);

    // R8: completion events on line 1
    step(10'b01_0101_0101, 0, '0);
    idle();
    idle();
    check(irq_o[1] == 1'b1, "R8 done line", 32'(irq_o), 32'h6);

    // mixed traffic, compared by the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      step(10'($urandom) & 10'($urandom), ($urandom % 4) == 0, d);
    end
    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule